// File: doc/BRIEF.md
# Four-Operand Signed Mantissa Adder

This block is the mantissa summation core of a floating-point adder that takes up to four inputs. It receives four magnitudes that have already been aligned to a common exponent. Each magnitude comes with a flag that asks for it to be subtracted rather than added. The block returns their signed total as a two's-complement value two bits wider than the inputs. Exponent handling, alignment shifts and normalization belong to the neighbouring stages.

Negation costs no adder width. A negated magnitude is bitwise inverted, and the +1 that completes its two's complement is deferred. Two carry-save stages reduce the four operands to a sum vector and a carry vector. Each carry vector is shifted left by one place, which leaves its bit 0 empty, and a deferred +1 is dropped into that empty slot. A third +1, if one exists, rides in as the carry-in of the final carry-propagate adder. No operand is sign-extended. A two-bit compensation constant, chosen from how many operands are negated, is added into the top two result bits instead.

Inputs are captured in a register stage and the sum leaves from a second register stage. A result therefore appears two clock edges after its operands, with a valid strobe. A request with all four operands negated lies outside the contract, and its output is unspecified.

Top module: `msum_quad_adder`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_sum` is 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` two rising edges later. No `out_valid` appears without a matching input.
- R3: When no negate flag is set, `out_sum` equals the exact unsigned sum of the four magnitudes, including when all four are at their maximum value.
- R4: When a single operand is negated, its magnitude is subtracted. The result is the 26-bit two's-complement value of the signed sum, taken modulo 2^26.
- R5: Any set of two or three negate flags, in any bit positions of `in_neg`, gives the signed sum modulo 2^26. Bit i of `in_neg` belongs to operand i, which sits at `in_mag[i*24 +: 24]`. Setting all four flags is illegal.
- R6: Negating a zero magnitude leaves the total unchanged.
- R7: While `out_valid` is low, `out_sum` holds the last result.
- R8: Inputs presented on consecutive cycles give results on consecutive cycles, in the order they were presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and flags are valid this cycle |
| in_mag | input | 96 | Four aligned magnitudes; operand i at bits i*24 +: 24 |
| in_neg | input | 4 | Per-operand subtract flag; bit i belongs to operand i |
| out_valid | output | 1 | `out_sum` carries a new result |
| out_sum | output | 26 | Two's-complement sum of the four signed operands |

## Verification
The hardest case to reach is three negated operands together with magnitude patterns that make carries run through the full width. Only then are all three deferred carry-ins in use at once, and only then does the compensation constant have to cancel a carry out of bit 23.

The stimulus walks through every placement of one, two and three negate flags. It pairs them with all-ones, all-zeros and single-bit magnitudes. A back-to-back random stream then covers any mix of flags except the illegal all-four case.

// File: rtl/msum_pkg.sv
package msum_pkg;
  localparam int NUM_OPS  = 4;
  localparam int MAX_NEG  = 3;
  localparam int CNT_W    = 2;
endpackage

// File: rtl/msum_csa.sv
// One row of 3:2 compressors. cry[i] carries weight 2^(i+1).
module msum_csa #(
  parameter int W = 24
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum,
  output logic [W-1:0] cry
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ c[i];
    assign cry[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end
endmodule

// File: rtl/msum_negctl.sv
// Turns the negate flags into three deferred +1 injections and the
// two-bit sign compensation (minus the count, modulo four).
module msum_negctl
  import msum_pkg::*;
(
  input  logic [NUM_OPS-1:0] neg,
  output logic [MAX_NEG-1:0] cin,
  output logic [CNT_W-1:0]   comp
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_OPS; i++) cnt = cnt + CNT_W'(neg[i]);
  end

  for (genvar k = 0; k < MAX_NEG; k++) begin : g_cin
    assign cin[k] = (cnt > CNT_W'(k));
  end

  assign comp = CNT_W'(0) - cnt;
endmodule

// File: rtl/msum_core.sv
// Combinational datapath: invert, two carry-save rows, one carry-propagate adder.
module msum_core
  import msum_pkg::*;
#(
  parameter int MAG_W = 24
) (
  input  logic [NUM_OPS*MAG_W-1:0] mag,
  input  logic [NUM_OPS-1:0]       neg,
  output logic [MAG_W+1:0]         total
);
  localparam int CPA_W = MAG_W + 1;
  localparam int RES_W = MAG_W + 2;

  logic [MAG_W-1:0] opx [NUM_OPS];
  logic [MAX_NEG-1:0] cin;
  logic [CNT_W-1:0]   comp;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_inv
    assign opx[i] = neg[i] ? ~mag[i*MAG_W +: MAG_W] : mag[i*MAG_W +: MAG_W];
  end

  msum_negctl u_ctl (.neg(neg), .cin(cin), .comp(comp));

  logic [MAG_W-1:0] s1, c1, c1s, s2, c2, c2s;

  msum_csa #(.W(MAG_W)) u_csa1 (.a(opx[0]), .b(opx[1]), .c(opx[2]), .sum(s1), .cry(c1));

  // shift carries up one place; the vacant bit 0 takes a deferred +1
  assign c1s = {c1[MAG_W-2:0], cin[0]};

  // top carry of the first row is not compressed again; it rides to the final adder
  msum_csa #(.W(MAG_W)) u_csa2 (.a(s1), .b(c1s), .c(opx[3]), .sum(s2), .cry(c2));

  assign c2s = {c2[MAG_W-2:0], cin[1]};

  logic [CPA_W-1:0] cpa_a, cpa_b;
  logic [RES_W-1:0] cpa_sum;

  assign cpa_a   = {c1[MAG_W-1], s2};
  assign cpa_b   = {c2[MAG_W-1], c2s};
  assign cpa_sum = RES_W'(cpa_a) + RES_W'(cpa_b) + RES_W'(cin[2]);

  assign total = {cpa_sum[RES_W-1:MAG_W] + comp, cpa_sum[MAG_W-1:0]};
endmodule

// File: rtl/msum_quad_adder.sv
module msum_quad_adder
  import msum_pkg::*;
#(
  parameter int MAG_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [4*MAG_W-1:0]       in_mag,
  input  logic [3:0]               in_neg,
  output logic                     out_valid,
  output logic [MAG_W+1:0]         out_sum
);
  localparam int RES_W = MAG_W + 2;

  logic                     v_q;
  logic [NUM_OPS*MAG_W-1:0] mag_q;
  logic [NUM_OPS-1:0]       neg_q;
  logic [RES_W-1:0]         total;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      mag_q <= '0;
      neg_q <= '0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        mag_q <= in_mag;
        neg_q <= in_neg;
      end
    end
  end

  msum_core #(.MAG_W(MAG_W)) u_core (.mag(mag_q), .neg(neg_q), .total(total));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= v_q;
      if (v_q) out_sum <= total;
    end
  end
endmodule

// File: rtl/msum_quad_adder_chk.sv
module msum_quad_adder_chk #(
  parameter int MAG_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [3:0]       in_neg,
  input logic             out_valid,
  input logic [MAG_W+1:0] out_sum
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!out_valid && out_sum == '0)); // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst) in_valid |=> ##1 out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid, 2)); // R2
  AST_NEG_LIMIT: assert property (@(posedge clk) disable iff (rst) in_valid |-> ($countones(in_neg) <= 3)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !out_valid |-> $stable(out_sum)); // R7
endmodule

bind msum_quad_adder msum_quad_adder_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_neg(in_neg),
  .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/sim_msum_quad_adder.sv
`timescale 1ns/1ps
module sim_msum_quad_adder;
  localparam int W  = 24;
  localparam int RW = W + 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [4*W-1:0]  in_mag = '0;
  logic [3:0]      in_neg = '0;
  logic            out_valid;
  logic [RW-1:0]   out_sum;

  always #2.5 clk = ~clk;

  msum_quad_adder #(.MAG_W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mag(in_mag), .in_neg(in_neg),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [RW-1:0] last_seen = '0;

  typedef struct {
    logic [RW-1:0] exp;
    int            due;
    string         req;
  } item_t;
  item_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: called just after a rising edge; pushes the reference result
  task automatic send(input logic [W-1:0] m0, input logic [W-1:0] m1,
                      input logic [W-1:0] m2, input logic [W-1:0] m3,
                      input logic [3:0] ng, input string req);
    logic [W-1:0]  m [4];
    logic [RW-1:0] acc;
    item_t it;
    m[0] = m0; m[1] = m1; m[2] = m2; m[3] = m3;
    acc = '0;
    for (int i = 0; i < 4; i++) begin
      if (ng[i]) acc = acc - RW'(m[i]);
      else       acc = acc + RW'(m[i]);
    end
    in_valid = 1'b1;
    in_mag   = {m3, m2, m1, m0};
    in_neg   = ng;
    it.exp = acc; it.due = cyc + 2; it.req = req;
    sb.push_back(it);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        tests++; fails++;
        $display("FAIL R2: actual out_valid=1 expected no pending result");
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.req, out_sum, it.exp);
        tests++;
        if (cyc != it.due) begin
          fails++;
          $display("FAIL R2: actual result cycle %0d expected %0d", cyc, it.due);
        end
        last_seen = out_sum;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [W-1:0] MAX = {W{1'b1}};

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", RW'(out_valid), '0);
    check("R1", out_sum, '0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check("R1", RW'(out_valid), '0);
    check("R1", out_sum, '0);
    @(posedge clk); #1;

    // R3: pure additions including maximum magnitudes
    send(24'd1, 24'd2, 24'd3, 24'd4, 4'b0000, "R3");
    send(MAX, MAX, MAX, MAX, 4'b0000, "R3");
    send(MAX, 24'd1, 24'd0, 24'h800000, 4'b0000, "R3");
    idle(4);
    // R7: output held while idle
    check("R7", out_sum, last_seen);
    check("R7", out_sum, RW'(MAX) + 26'd1 + 26'h800000);

    // R4: a single negation in every position
    for (int p = 0; p < 4; p++) begin
      send(24'd100, 24'd7, MAX, 24'h123456, 4'(1 << p), "R4");
      send(MAX, MAX, MAX, MAX, 4'(1 << p), "R4");
    end
    send(24'd5, 24'd0, 24'd0, 24'd0, 4'b0001, "R4");

    // R6: negated zero changes nothing
    send(24'd0, 24'd9, 24'd10, 24'd11, 4'b0001, "R6");
    send(24'd0, 24'd0, 24'd0, 24'd0, 4'b0111, "R6");
    send(24'd3, 24'd0, 24'd0, 24'd4, 4'b0110, "R6");

    // R5: all placements of two and three flags
    for (int f = 0; f < 15; f++) begin
      if ($countones(f) >= 2) begin
        send(MAX, MAX, MAX, MAX, 4'(f), "R5");
        send(24'd1, 24'h800000, MAX, 24'd0, 4'(f), "R5");
        send(24'h0F0F0F, 24'h00FFFF, 24'hFFFF00, 24'h000001, 4'(f), "R5");
      end
    end
    idle(4);
    check("R7", out_sum, last_seen);

    // R8: back-to-back random stream
    for (int k = 0; k < 300; k++) begin
      logic [3:0] ng;
      ng = 4'($urandom);
      if (ng == 4'hF) ng = 4'h7;
      send(W'($urandom), W'($urandom), W'($urandom), W'($urandom), ng, "R8");
    end
    idle(6);
    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R8: actual %0d pending expected 0", sb.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule